// File: doc/BRIEF.md
# Thread-Block Admission Controller

This block places the thread blocks of one kernel launch onto a small array of compute units. A launch gives a block count and what each block needs: its thread count, its registers per thread and its shared-memory bytes. Every block of a launch needs the same amount, so the controller captures the launch once. It then issues block IDs in ascending order. A block goes to a unit only when that unit has room for the whole block in every pool: shared memory, registers, thread slots and block slots.

A unit gets its resources back only when a completion pulse reports that every warp of one of its resident blocks has finished. Blocks that have not been placed wait their turn. The next one is issued as soon as a completion leaves enough room somewhere. If a single block could not fit even on an empty unit, the launch is refused and an error flag is raised. A done flag marks the point at which every block of an accepted launch has been issued and retired.

Top module: `blk_admit`

## Requirements
- R1: A block is placed on a unit only if the unit's free shared memory covers the block's byte count and its free registers cover registers-per-thread times the raw thread count. With 65536 registers per unit and 30720 registers per block, at most two blocks share a unit.
- R2: The descriptor is captured when `launch_valid` is seen while the controller is idle. A `launch_valid` that arrives while `busy` is high is ignored and has no effect on the running launch.
- R3: Thread slots are charged as the thread count rounded up to a multiple of 32. A 673-thread block therefore uses 704 slots, and a 2017-thread block uses the full 2048 slots of a unit.
- R4: A unit holds at most `BLK_CAP` resident blocks (default 8), even when all other pools have room.
- R5: A launch whose single block exceeds the capacity of an empty unit in shared memory, registers or thread slots is refused. `launch_err` goes high, `busy` stays low and no block is offered. The flag stays high until the next launch is accepted.
- R6: A block's resources return to its unit only on a completion pulse for that unit. A block that does not fit waits, with `disp_valid` low, until a completion makes room. It is then offered to the unit that was freed.
- R7: Block IDs are offered in increasing order starting at 0. The lowest-numbered unit that fits wins. At most one block is offered per cycle. While `disp_ready` is low, `disp_valid`, `disp_unit` and `disp_block` hold steady.
- R8: `done` rises once every block of the launch has been both dispatched and retired. `busy` is low at that point, and `done` stays high until the next launch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| launch_valid | input | 1 | Launch request; taken only when idle |
| launch_blocks | input | CNT_W | Number of blocks in the launch |
| launch_threads | input | THR_W | Threads per block |
| launch_regs_per_thread | input | RPT_W | Registers per thread |
| launch_smem | input | SMEM_W | Shared-memory bytes per block |
| busy | output | 1 | A launch is in progress |
| launch_err | output | 1 | Last launch was refused |
| done | output | 1 | Last accepted launch fully retired |
| disp_valid | output | 1 | A block placement is offered |
| disp_ready | input | 1 | Receiver accepts the offered placement |
| disp_unit | output | UNIT_W | Unit chosen for the offered block |
| disp_block | output | CNT_W | ID of the offered block |
| cmpl_valid | input | 1 | One-cycle pulse: a block on `cmpl_unit` has fully finished |
| cmpl_unit | input | UNIT_W | Unit of the retiring block |

## Verification
A ledger that drifts (a pool debited twice, or credited without a completion) shows up at the dispatch port. A block either appears on a unit that should be full, or never appears after the completion that should have made room. Rounding and capacity faults show up in the first fill pass of a launch, within a few cycles of `busy` rising, because the order of units reveals how many blocks each unit took. A faulty retire count shows up as `done` rising early, before the final completion, or never rising at all.

// File: rtl/blk_admit_pkg.sv
package blk_admit_pkg;
    typedef enum logic {
        ADM_IDLE,
        ADM_RUN
    } adm_state_e;
endpackage

// File: rtl/blk_admit_demand.sv
// Per-block demand: thread slots rounded up to the warp size, register total,
// and whether one block fits an empty unit at all.
module blk_admit_demand #(
    parameter int THR_W    = 11,
    parameter int RPT_W    = 8,
    parameter int SMEM_W   = 17,
    parameter int WARP     = 32,
    parameter int SMEM_CAP = 49152,
    parameter int REG_CAP  = 65536,
    parameter int THR_CAP  = 2048,
    localparam int TS_W    = THR_W + 1,
    localparam int RG_W    = THR_W + RPT_W
) (
    input  logic [THR_W-1:0]  threads,
    input  logic [RPT_W-1:0]  regs_per_thread,
    input  logic [SMEM_W-1:0] smem,
    output logic [TS_W-1:0]   thr_slots,
    output logic [RG_W-1:0]   regs_total,
    output logic              fits_empty
);
    localparam logic [TS_W-1:0] PAD = TS_W'(WARP - 1);

    logic [TS_W-1:0] padded;

    always_comb begin
        padded     = {1'b0, threads} + PAD;
        thr_slots  = padded & ~PAD;
        regs_total = RG_W'(regs_per_thread) * RG_W'(threads);
        fits_empty = (32'(smem) <= 32'(SMEM_CAP))
                  && (32'(regs_total) <= 32'(REG_CAP))
                  && (32'(thr_slots) <= 32'(THR_CAP));
    end
endmodule

// File: rtl/blk_admit_ledger.sv
// Free-resource ledger of one compute unit.
module blk_admit_ledger #(
    parameter int SMEM_W   = 17,
    parameter int RG_W     = 19,
    parameter int TS_W     = 12,
    parameter int SMEM_CAP = 49152,
    parameter int REG_CAP  = 65536,
    parameter int THR_CAP  = 2048,
    parameter int BLK_CAP  = 8,
    localparam int SM_F    = $clog2(SMEM_CAP + 1),
    localparam int RG_F    = $clog2(REG_CAP + 1),
    localparam int TH_F    = $clog2(THR_CAP + 1),
    localparam int BK_F    = $clog2(BLK_CAP + 1),
    localparam int SM_C    = (SM_F > SMEM_W) ? SM_F : SMEM_W,
    localparam int RG_C    = (RG_F > RG_W) ? RG_F : RG_W,
    localparam int TH_C    = (TH_F > TS_W) ? TH_F : TS_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [SMEM_W-1:0] need_smem,
    input  logic [RG_W-1:0]   need_regs,
    input  logic [TS_W-1:0]   need_thr,
    input  logic              alloc,
    input  logic              release_blk,
    output logic              fits,
    output logic              occupied
);
    typedef struct packed {
        logic [SM_F-1:0] smem;
        logic [RG_F-1:0] regs;
        logic [TH_F-1:0] thr;
        logic [BK_F-1:0] blk;
    } pool_t;

    pool_t pool_d, pool_q;

    always_comb begin
        pool_d   = pool_q;
        fits     = (SM_C'(need_smem) <= SM_C'(pool_q.smem))
                && (RG_C'(need_regs) <= RG_C'(pool_q.regs))
                && (TH_C'(need_thr)  <= TH_C'(pool_q.thr))
                && (pool_q.blk != '0);
        occupied = pool_q.blk != BK_F'(BLK_CAP);
        if (alloc) begin
            pool_d.smem = pool_d.smem - SM_F'(need_smem);
            pool_d.regs = pool_d.regs - RG_F'(need_regs);
            pool_d.thr  = pool_d.thr  - TH_F'(need_thr);
            pool_d.blk  = pool_d.blk  - BK_F'(1);
        end
        if (release_blk) begin
            pool_d.smem = pool_d.smem + SM_F'(need_smem);
            pool_d.regs = pool_d.regs + RG_F'(need_regs);
            pool_d.thr  = pool_d.thr  + TH_F'(need_thr);
            pool_d.blk  = pool_d.blk  + BK_F'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pool_q.smem <= SM_F'(SMEM_CAP);
            pool_q.regs <= RG_F'(REG_CAP);
            pool_q.thr  <= TH_F'(THR_CAP);
            pool_q.blk  <= BK_F'(BLK_CAP);
        end else begin
            pool_q <= pool_d;
        end
    end

    AST_ALLOC_FITS: assert property (@(posedge clk) disable iff (!rst_n)
        alloc |-> fits); // R1
    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        (pool_q.smem <= SM_F'(SMEM_CAP)) && (pool_q.regs <= RG_F'(REG_CAP))
        && (pool_q.thr <= TH_F'(THR_CAP)) && (pool_q.blk <= BK_F'(BLK_CAP))); // R6
    AST_BLK_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
        alloc |-> (pool_q.blk != '0)); // R4
    AST_RELEASE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        release_blk |-> occupied); // R6
endmodule

// File: rtl/blk_admit.sv
module blk_admit #(
    parameter int NUM_UNITS = 4,
    parameter int SMEM_CAP  = 49152,
    parameter int REG_CAP   = 65536,
    parameter int THR_CAP   = 2048,
    parameter int BLK_CAP   = 8,
    parameter int WARP      = 32,
    parameter int CNT_W     = 16,
    parameter int THR_W     = 11,
    parameter int RPT_W     = 8,
    parameter int SMEM_W    = 17,
    localparam int UNIT_W   = (NUM_UNITS > 1) ? $clog2(NUM_UNITS) : 1,
    localparam int TS_W     = THR_W + 1,
    localparam int RG_W     = THR_W + RPT_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              launch_valid,
    input  logic [CNT_W-1:0]  launch_blocks,
    input  logic [THR_W-1:0]  launch_threads,
    input  logic [RPT_W-1:0]  launch_regs_per_thread,
    input  logic [SMEM_W-1:0] launch_smem,
    output logic              busy,
    output logic              launch_err,
    output logic              done,
    output logic              disp_valid,
    input  logic              disp_ready,
    output logic [UNIT_W-1:0] disp_unit,
    output logic [CNT_W-1:0]  disp_block,
    input  logic              cmpl_valid,
    input  logic [UNIT_W-1:0] cmpl_unit
);
    import blk_admit_pkg::*;

    typedef struct packed {
        adm_state_e        st;
        logic [CNT_W-1:0]  total;
        logic [CNT_W-1:0]  next_id;
        logic [CNT_W-1:0]  retired;
        logic [SMEM_W-1:0] n_smem;
        logic [RG_W-1:0]   n_regs;
        logic [TS_W-1:0]   n_thr;
        logic              offer_v;
        logic [UNIT_W-1:0] offer_unit;
        logic [CNT_W-1:0]  offer_id;
        logic              err;
        logic              done;
    } ctl_t;

    ctl_t q, d;

    logic [TS_W-1:0]      dem_thr;
    logic [RG_W-1:0]      dem_regs;
    logic                 dem_fits;
    logic [NUM_UNITS-1:0] fits;
    logic [NUM_UNITS-1:0] occupied;
    logic [NUM_UNITS-1:0] alloc_vec;
    logic [NUM_UNITS-1:0] rel_vec;
    logic [UNIT_W-1:0]    pick;
    logic                 any_fit;
    logic                 slot_free;

    blk_admit_demand #(
        .THR_W(THR_W), .RPT_W(RPT_W), .SMEM_W(SMEM_W), .WARP(WARP),
        .SMEM_CAP(SMEM_CAP), .REG_CAP(REG_CAP), .THR_CAP(THR_CAP)
    ) u_demand (
        .threads(launch_threads),
        .regs_per_thread(launch_regs_per_thread),
        .smem(launch_smem),
        .thr_slots(dem_thr),
        .regs_total(dem_regs),
        .fits_empty(dem_fits)
    );

    for (genvar g = 0; g < NUM_UNITS; g++) begin : g_unit
        blk_admit_ledger #(
            .SMEM_W(SMEM_W), .RG_W(RG_W), .TS_W(TS_W),
            .SMEM_CAP(SMEM_CAP), .REG_CAP(REG_CAP),
            .THR_CAP(THR_CAP), .BLK_CAP(BLK_CAP)
        ) u_ledger (
            .clk(clk),
            .rst_n(rst_n),
            .need_smem(q.n_smem),
            .need_regs(q.n_regs),
            .need_thr(q.n_thr),
            .alloc(alloc_vec[g]),
            .release_blk(rel_vec[g]),
            .fits(fits[g]),
            .occupied(occupied[g])
        );
    end

    // lowest-numbered unit with room wins
    always_comb begin
        pick    = '0;
        any_fit = 1'b0;
        for (int u = NUM_UNITS - 1; u >= 0; u--) begin
            if (fits[u]) begin
                pick    = UNIT_W'(u);
                any_fit = 1'b1;
            end
        end
    end

    always_comb begin
        d         = q;
        alloc_vec = '0;
        rel_vec   = '0;
        slot_free = !q.offer_v || disp_ready;
        case (q.st)
            ADM_IDLE: begin
                if (launch_valid) begin
                    d.err  = !dem_fits;
                    d.done = 1'b0;
                    if (dem_fits) begin
                        d.st      = ADM_RUN;
                        d.total   = launch_blocks;
                        d.next_id = '0;
                        d.retired = '0;
                        d.n_smem  = launch_smem;
                        d.n_regs  = dem_regs;
                        d.n_thr   = dem_thr;
                    end
                end
            end
            default: begin
                if (q.offer_v && disp_ready) begin
                    d.offer_v = 1'b0;
                end
                if (slot_free && any_fit && (q.next_id != q.total)) begin
                    d.offer_v        = 1'b1;
                    d.offer_unit     = pick;
                    d.offer_id       = q.next_id;
                    d.next_id        = q.next_id + CNT_W'(1);
                    alloc_vec[pick]  = 1'b1;
                end
                if (cmpl_valid && (int'(cmpl_unit) < NUM_UNITS) && occupied[cmpl_unit]) begin
                    rel_vec[cmpl_unit] = 1'b1;
                    d.retired          = q.retired + CNT_W'(1);
                end
                if ((q.retired == q.total) && (q.next_id == q.total) && !q.offer_v) begin
                    d.st   = ADM_IDLE;
                    d.done = 1'b1;
                end
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign busy       = (q.st == ADM_RUN);
    assign launch_err = q.err;
    assign done       = q.done;
    assign disp_valid = q.offer_v;
    assign disp_unit  = q.offer_unit;
    assign disp_block = q.offer_id;

    AST_OFFER_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (disp_valid && !disp_ready) |=> (disp_valid && $stable(disp_unit) && $stable(disp_block))); // R7
    AST_ERR_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        launch_err |-> (!disp_valid && !busy)); // R5
    AST_DONE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!busy && !disp_valid)); // R8
    AST_DESC_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> ($stable(q.total) && $stable(q.n_smem) && $stable(q.n_regs) && $stable(q.n_thr))); // R2
    AST_ONE_ALLOC: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(alloc_vec)); // R7
endmodule

// File: tb/blk_admit_bench.sv
module blk_admit_bench;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        launch_valid = 1'b0;
    logic [15:0] launch_blocks = '0;
    logic [10:0] launch_threads = '0;
    logic [7:0]  launch_regs_per_thread = '0;
    logic [16:0] launch_smem = '0;
    logic        busy, launch_err, done, disp_valid;
    logic        disp_ready = 1'b1;
    logic [1:0]  disp_unit;
    logic [15:0] disp_block;
    logic        cmpl_valid = 1'b0;
    logic [1:0]  cmpl_unit = '0;

    int n_checks = 0;
    int n_fail   = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    blk_admit u_blk_admit (
        .clk(clk), .rst_n(rst_n),
        .launch_valid(launch_valid), .launch_blocks(launch_blocks),
        .launch_threads(launch_threads), .launch_regs_per_thread(launch_regs_per_thread),
        .launch_smem(launch_smem),
        .busy(busy), .launch_err(launch_err), .done(done),
        .disp_valid(disp_valid), .disp_ready(disp_ready),
        .disp_unit(disp_unit), .disp_block(disp_block),
        .cmpl_valid(cmpl_valid), .cmpl_unit(cmpl_unit)
    );

    task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    endtask

    // all tasks start and end at a falling edge
    task automatic do_launch(input int blocks, input int thr, input int rpt, input int smem);
        launch_blocks          = 16'(blocks);
        launch_threads         = 11'(thr);
        launch_regs_per_thread = 8'(rpt);
        launch_smem            = 17'(smem);
        launch_valid           = 1'b1;
        @(negedge clk);
        launch_valid = 1'b0;
    endtask

    task automatic expect_disp(input int unit, input int id, input string req);
        int waited = 0;
        while (!disp_valid && waited < 40) begin
            @(negedge clk);
            waited++;
        end
        chk(disp_valid, req, "offer present", int'(disp_valid), 1);
        chk(int'(disp_block) == id, req, "block id", int'(disp_block), id);
        chk(int'(disp_unit) == unit, req, "unit", int'(disp_unit), unit);
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic expect_idle(input int cycles, input string req);
        for (int i = 0; i < cycles; i++) begin
            chk(!disp_valid, req, "no offer while full", int'(disp_valid), 0);
            @(negedge clk);
        end
    endtask

    task automatic complete(input int unit);
        cmpl_valid = 1'b1;
        cmpl_unit  = 2'(unit);
        @(negedge clk);
        cmpl_valid = 1'b0;
    endtask

    task automatic drain_pairs();
        for (int u = 0; u < 4; u++) begin
            complete(u);
            complete(u);
        end
    endtask

    task automatic wait_done(input string req);
        int waited = 0;
        while (!done && waited < 20) begin
            @(negedge clk);
            waited++;
        end
        chk(done, req, "done raised", int'(done), 1);
        chk(!busy, req, "busy low at done", int'(busy), 0);
    endtask

    // R1 register pool, R2 ignored relaunch, R6 wait for completion, R7 order and hold
    task automatic test_regs();
        do_launch(10, 256, 120, 0);
        disp_ready = 1'b0;
        @(negedge clk);
        @(negedge clk);
        chk(disp_valid && disp_block == 0 && disp_unit == 0, "R7", "offer while not ready", int'(disp_block), 0);
        @(negedge clk);
        @(negedge clk);
        chk(disp_valid && disp_block == 0 && disp_unit == 0, "R7", "offer held stable", int'(disp_unit), 0);
        disp_ready = 1'b1;
        for (int b = 0; b < 8; b++) expect_disp(b / 2, b, "R1");
        expect_idle(4, "R1");
        do_launch(1, 32, 1, 0);
        chk(busy, "R2", "busy after ignored launch", int'(busy), 1);
        expect_idle(4, "R2");
        complete(2);
        expect_disp(2, 8, "R6");
        complete(1);
        expect_disp(1, 9, "R6");
        for (int u = 0; u < 4; u++) begin
            complete(u);
            if (u < 3) complete(u);
        end
        @(negedge clk);
        @(negedge clk);
        chk(!done && busy, "R8", "done before last retire", int'(done), 0);
        complete(3);
        wait_done("R8");
    endtask

    // R3 thread slot rounding
    task automatic test_rounding();
        do_launch(9, 673, 1, 0);
        for (int b = 0; b < 8; b++) expect_disp(b / 2, b, "R3");
        expect_idle(3, "R3");
        complete(0);
        expect_disp(0, 8, "R3");
        drain_pairs();
        wait_done("R8");
        do_launch(5, 2017, 1, 0);
        for (int b = 0; b < 4; b++) expect_disp(b, b, "R3");
        expect_idle(3, "R3");
        complete(1);
        expect_disp(1, 4, "R3");
        for (int u = 0; u < 4; u++) complete(u);
        wait_done("R8");
    endtask

    // R4 block-slot cap
    task automatic test_blk_cap();
        do_launch(33, 32, 1, 0);
        for (int b = 0; b < 32; b++) expect_disp(b / 8, b, "R4");
        expect_idle(3, "R4");
        complete(3);
        expect_disp(3, 32, "R4");
        for (int u = 0; u < 4; u++)
            for (int k = 0; k < 8; k++) complete(u);
        wait_done("R8");
    endtask

    // R1 shared-memory pool
    task automatic test_smem();
        do_launch(5, 32, 1, 20000);
        for (int b = 0; b < 5; b++) expect_disp(b / 2, b, "R1");
        complete(0); complete(0); complete(1); complete(1); complete(2);
        wait_done("R8");
    endtask

    // R5 refused launches
    task automatic test_error();
        do_launch(4, 32, 1, 50000);
        chk(launch_err, "R5", "error on smem", int'(launch_err), 1);
        chk(!busy, "R5", "busy stays low", int'(busy), 0);
        expect_idle(3, "R5");
        do_launch(4, 1024, 255, 0);
        chk(launch_err, "R5", "error on registers", int'(launch_err), 1);
        expect_idle(3, "R5");
        do_launch(1, 32, 1, 0);
        chk(!launch_err, "R5", "error cleared by good launch", int'(launch_err), 0);
        expect_disp(0, 0, "R5");
        complete(0);
        wait_done("R8");
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        n_fail++;
        $display("FAIL watchdog: actual 0 expected 1 (run finished)");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!disp_valid, "R7", "reset offer", int'(disp_valid), 0);
        chk(!busy, "R2", "reset busy", int'(busy), 0);
        chk(!done, "R8", "reset done", int'(done), 0);
        chk(!launch_err, "R5", "reset error", int'(launch_err), 0);
        test_regs();
        test_rounding();
        test_blk_cap();
        test_smem();
        test_error();
        finish_run();
    end
endmodule